// File: doc/BRIEF.md
# 64-bit Integer ALU with Bit-Manipulation Operations

This block is a purely combinational integer ALU for a 64-bit scalar pipeline. Each cycle it takes two 64-bit source operands and a 7-bit operation code. It returns a 64-bit result and a one-bit branch-taken flag. The operation space is grouped: the top three opcode bits pick an operation class, and the low four bits pick the operation inside that class.

The supported classes are:
- base shifts and rotates, plus single-bit clear, set and extract;
- 32-bit word operations whose results are sign-extended to 64 bits;
- plain and shift-and-add additions, with an optional zero-extension of the low word of the first operand;
- subtract, set-less-than, and signed or unsigned minimum and maximum;
- plain and inverted logic, byte-wise OR-combine, sign-extension of a byte or halfword, and byte reversal;
- branch condition evaluation.

Internally, a control decoder turns the opcode into a small struct of strobes, and a datapath acts on those strobes. Issue logic places the block in an execute stage. It drives the operands and opcode, and it takes the result and the taken flag in the same cycle.

Top module: `rv_bitalu`

## Requirements
- R1: An opcode not listed in R2 to R11 (for example 0000100, 0010001, 1110100, 1111111, 1010010) gives a result of 0 and a taken flag of 0.
- R2: For opcodes with bits [6:4] = 111, the comparison type is set by bits [3:2], and bit 1 inverts the outcome:
  - 00 is equality, 10 is signed less-than, 11 is unsigned less-than;
  - the taken flag is 1 when the comparison, after the optional inversion, is true: 1110000 equal, 1110010 not equal, 1111000 signed less, 1111010 signed greater-or-equal, 1111100 unsigned less, 1111110 unsigned greater-or-equal;
  - the result is 0 for these branch opcodes;
  - the taken flag is 0 for every opcode outside this class.
- R3: These 64-bit shifts and rotates use only bits [5:0] of operand 2 as the amount: 0000001 shifts left, 0000101 shifts right logically, 0000111 shifts right arithmetically, 0001001 rotates left, 0001011 rotates right.
- R4: Opcode 0000000 zero-extends bits [31:0] of operand 1 and then shifts the value left by bits [5:0] of operand 2.
- R5: The single-bit operations take their bit index from bits [5:0] of operand 2. Opcode 0000010 clears the indexed bit of operand 1, opcode 0000011 sets it, and opcode 0000110 returns it in bit 0 with zeros above.
- R6: The word operations compute on 32 bits and sign-extend bit 31 into bits [63:32]. Their shift and rotate amount is bits [4:0] of operand 2. The opcodes are 0010000 add, 0010010 subtract, 0011000 left shift, 0011001 logical right shift of bits [31:0], 0011010 arithmetic right shift of bits [31:0], 0011100 rotate left, 0011101 rotate right.
- R7: The add forms return operand 2 plus operand 1 shifted left by N, modulo 2^64:
  - 0100001 with N = 0, 0101001 with N = 1, 0101011 with N = 2, 0101101 with N = 3;
  - 0100000, 0101000, 0101010 and 0101100 use N = 0, 1, 2 and 3 but first zero-extend bits [31:0] of operand 1.
- R8: Opcode 0110000 returns operand 1 minus operand 2. Opcode 0110001 returns 1 when operand 1 is unsigned-less than operand 2, otherwise 0. Opcode 0110010 does the same with a signed compare.
- R9: Minimum and maximum return one of the two operands: 0110100 unsigned maximum, 0110101 unsigned minimum, 0110110 signed maximum, 0110111 signed minimum.
- R10: The logic opcodes are 1000000 AND, 1000001 AND with inverted operand 2, 1000010 OR, 1000011 OR with inverted operand 2, 1000100 XOR and 1000101 XNOR.
- R11: These opcodes act on operand 1 only:
  - 1000110 sets each byte to 0xFF if any of its bits is set and to 0x00 otherwise;
  - 1001000 sign-extends bits [7:0];
  - 1001010 sign-extends bits [15:0];
  - 1010001 reverses the byte order, so byte 0 goes to byte 7.

Port | Direction | Width | Description
## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| opCode | input | 7 | Operation code; bits [6:4] select the class |
| srcA | input | 64 | Operand 1 |
| srcB | input | 64 | Operand 2; supplies the shift amount or bit index where used |
| result | output | 64 | Operation result, 0 for branches and unassigned codes |
| brTaken | output | 1 | Branch condition outcome, 0 for non-branch codes |

## Verification
The block holds no state, so a wrong decode or a wrong datapath strobe shows up at the ports in the same evaluation as the opcode that causes it. A mis-decoded class typically gives a nonzero result on a branch or an unassigned code, or a taken flag outside the branch class. A wrong amount mask shows up when operand 2 carries bits above the amount field; the stimulus sets bit 6, and bit 5 for the word forms, to expose this. Every listed opcode is applied across operand pairs chosen to hit sign boundaries, equal operands and zero amounts. The whole 128-entry opcode space is then swept, so that any code outside the listed ones can be seen to return zero.

// File: rtl/rv_bitalu_pkg.sv
package rv_bitalu_pkg;

  localparam int unsigned OP_W = 7;

  // opcode points
  localparam logic [OP_W-1:0] OPC_SLLIUW  = 7'h00;
  localparam logic [OP_W-1:0] OPC_SLL     = 7'h01;
  localparam logic [OP_W-1:0] OPC_BCLR    = 7'h02;
  localparam logic [OP_W-1:0] OPC_BSET    = 7'h03;
  localparam logic [OP_W-1:0] OPC_SRL     = 7'h05;
  localparam logic [OP_W-1:0] OPC_BEXT    = 7'h06;
  localparam logic [OP_W-1:0] OPC_SRA     = 7'h07;
  localparam logic [OP_W-1:0] OPC_ROL     = 7'h09;
  localparam logic [OP_W-1:0] OPC_ROR     = 7'h0B;
  localparam logic [OP_W-1:0] OPC_ADDW    = 7'h10;
  localparam logic [OP_W-1:0] OPC_SUBW    = 7'h12;
  localparam logic [OP_W-1:0] OPC_SLLW    = 7'h18;
  localparam logic [OP_W-1:0] OPC_SRLW    = 7'h19;
  localparam logic [OP_W-1:0] OPC_SRAW    = 7'h1A;
  localparam logic [OP_W-1:0] OPC_ROLW    = 7'h1C;
  localparam logic [OP_W-1:0] OPC_RORW    = 7'h1D;
  localparam logic [OP_W-1:0] OPC_ADDUW   = 7'h20;
  localparam logic [OP_W-1:0] OPC_ADD     = 7'h21;
  localparam logic [OP_W-1:0] OPC_SH1ADDUW = 7'h28;
  localparam logic [OP_W-1:0] OPC_SH1ADD  = 7'h29;
  localparam logic [OP_W-1:0] OPC_SH2ADDUW = 7'h2A;
  localparam logic [OP_W-1:0] OPC_SH2ADD  = 7'h2B;
  localparam logic [OP_W-1:0] OPC_SH3ADDUW = 7'h2C;
  localparam logic [OP_W-1:0] OPC_SH3ADD  = 7'h2D;
  localparam logic [OP_W-1:0] OPC_SUB     = 7'h30;
  localparam logic [OP_W-1:0] OPC_SLTU    = 7'h31;
  localparam logic [OP_W-1:0] OPC_SLT     = 7'h32;
  localparam logic [OP_W-1:0] OPC_MAXU    = 7'h34;
  localparam logic [OP_W-1:0] OPC_MINU    = 7'h35;
  localparam logic [OP_W-1:0] OPC_MAX     = 7'h36;
  localparam logic [OP_W-1:0] OPC_MIN     = 7'h37;
  localparam logic [OP_W-1:0] OPC_AND     = 7'h40;
  localparam logic [OP_W-1:0] OPC_ANDN    = 7'h41;
  localparam logic [OP_W-1:0] OPC_OR      = 7'h42;
  localparam logic [OP_W-1:0] OPC_ORN     = 7'h43;
  localparam logic [OP_W-1:0] OPC_XOR     = 7'h44;
  localparam logic [OP_W-1:0] OPC_XNOR    = 7'h45;
  localparam logic [OP_W-1:0] OPC_ORCB    = 7'h46;
  localparam logic [OP_W-1:0] OPC_SEXTB   = 7'h48;
  localparam logic [OP_W-1:0] OPC_SEXTH   = 7'h4A;
  localparam logic [OP_W-1:0] OPC_REV8    = 7'h51;
  localparam logic [OP_W-1:0] OPC_BEQ     = 7'h70;
  localparam logic [OP_W-1:0] OPC_BNE     = 7'h72;
  localparam logic [OP_W-1:0] OPC_BLT     = 7'h78;
  localparam logic [OP_W-1:0] OPC_BGE     = 7'h7A;
  localparam logic [OP_W-1:0] OPC_BLTU    = 7'h7C;
  localparam logic [OP_W-1:0] OPC_BGEU    = 7'h7E;

  typedef enum logic [3:0] {
    UNIT_NONE, UNIT_SHIFT, UNIT_BIT, UNIT_ARITH, UNIT_LESS, UNIT_MINMAX,
    UNIT_LOGIC, UNIT_ORCB, UNIT_SEXTB, UNIT_SEXTH, UNIT_REV8
  } unit_e;

  typedef enum logic [2:0] {SH_LEFT, SH_RLOG, SH_RARI, SH_ROL, SH_ROR} shift_e;
  typedef enum logic [1:0] {BIT_CLR, BIT_SET, BIT_EXT} bitop_e;
  typedef enum logic [1:0] {LG_AND, LG_OR, LG_XOR} logic_e;
  typedef enum logic [1:0] {BR_EQ, BR_LTS, BR_LTU} brcmp_e;

  // strobes from the decoder to the datapath
  typedef struct packed {
    unit_e      unit;
    logic       wordOp;
    logic       zextA;
    logic [1:0] preShift;
    logic       subtract;
    shift_e     shiftKind;
    bitop_e     bitOp;
    logic       invertB;
    logic_e     logicFn;
    logic       cmpSigned;
    logic       pickMax;
    logic       isBranch;
    brcmp_e     brCmp;
    logic       brInvert;
  } alu_strobes_t;

endpackage

// File: rtl/rv_bitalu_ctrl.sv
module rv_bitalu_ctrl
  import rv_bitalu_pkg::*;
(
  input  logic [OP_W-1:0] opCode,
  output alu_strobes_t    strobes
);

  always_comb begin
    strobes = '0;
    case (opCode)
      OPC_SLLIUW: begin strobes.unit = UNIT_SHIFT; strobes.shiftKind = SH_LEFT; strobes.zextA = 1'b1; end
      OPC_SLL:    begin strobes.unit = UNIT_SHIFT; strobes.shiftKind = SH_LEFT; end
      OPC_SRL:    begin strobes.unit = UNIT_SHIFT; strobes.shiftKind = SH_RLOG; end
      OPC_SRA:    begin strobes.unit = UNIT_SHIFT; strobes.shiftKind = SH_RARI; end
      OPC_ROL:    begin strobes.unit = UNIT_SHIFT; strobes.shiftKind = SH_ROL; end
      OPC_ROR:    begin strobes.unit = UNIT_SHIFT; strobes.shiftKind = SH_ROR; end
      OPC_BCLR:   begin strobes.unit = UNIT_BIT; strobes.bitOp = BIT_CLR; end
      OPC_BSET:   begin strobes.unit = UNIT_BIT; strobes.bitOp = BIT_SET; end
      OPC_BEXT:   begin strobes.unit = UNIT_BIT; strobes.bitOp = BIT_EXT; end

      OPC_ADDW:   begin strobes.unit = UNIT_ARITH; strobes.wordOp = 1'b1; end
      OPC_SUBW:   begin strobes.unit = UNIT_ARITH; strobes.wordOp = 1'b1; strobes.subtract = 1'b1; end
      OPC_SLLW:   begin strobes.unit = UNIT_SHIFT; strobes.wordOp = 1'b1; strobes.shiftKind = SH_LEFT; end
      OPC_SRLW:   begin strobes.unit = UNIT_SHIFT; strobes.wordOp = 1'b1; strobes.shiftKind = SH_RLOG; end
      OPC_SRAW:   begin strobes.unit = UNIT_SHIFT; strobes.wordOp = 1'b1; strobes.shiftKind = SH_RARI; end
      OPC_ROLW:   begin strobes.unit = UNIT_SHIFT; strobes.wordOp = 1'b1; strobes.shiftKind = SH_ROL; end
      OPC_RORW:   begin strobes.unit = UNIT_SHIFT; strobes.wordOp = 1'b1; strobes.shiftKind = SH_ROR; end

      OPC_ADDUW:    begin strobes.unit = UNIT_ARITH; strobes.zextA = 1'b1; end
      OPC_ADD:      begin strobes.unit = UNIT_ARITH; end
      OPC_SH1ADDUW: begin strobes.unit = UNIT_ARITH; strobes.zextA = 1'b1; strobes.preShift = 2'd1; end
      OPC_SH1ADD:   begin strobes.unit = UNIT_ARITH; strobes.preShift = 2'd1; end
      OPC_SH2ADDUW: begin strobes.unit = UNIT_ARITH; strobes.zextA = 1'b1; strobes.preShift = 2'd2; end
      OPC_SH2ADD:   begin strobes.unit = UNIT_ARITH; strobes.preShift = 2'd2; end
      OPC_SH3ADDUW: begin strobes.unit = UNIT_ARITH; strobes.zextA = 1'b1; strobes.preShift = 2'd3; end
      OPC_SH3ADD:   begin strobes.unit = UNIT_ARITH; strobes.preShift = 2'd3; end

      OPC_SUB:    begin strobes.unit = UNIT_ARITH; strobes.subtract = 1'b1; end
      OPC_SLTU:   begin strobes.unit = UNIT_LESS; end
      OPC_SLT:    begin strobes.unit = UNIT_LESS; strobes.cmpSigned = 1'b1; end
      OPC_MAXU:   begin strobes.unit = UNIT_MINMAX; strobes.pickMax = 1'b1; end
      OPC_MINU:   begin strobes.unit = UNIT_MINMAX; end
      OPC_MAX:    begin strobes.unit = UNIT_MINMAX; strobes.pickMax = 1'b1; strobes.cmpSigned = 1'b1; end
      OPC_MIN:    begin strobes.unit = UNIT_MINMAX; strobes.cmpSigned = 1'b1; end

      OPC_AND:    begin strobes.unit = UNIT_LOGIC; strobes.logicFn = LG_AND; end
      OPC_ANDN:   begin strobes.unit = UNIT_LOGIC; strobes.logicFn = LG_AND; strobes.invertB = 1'b1; end
      OPC_OR:     begin strobes.unit = UNIT_LOGIC; strobes.logicFn = LG_OR; end
      OPC_ORN:    begin strobes.unit = UNIT_LOGIC; strobes.logicFn = LG_OR; strobes.invertB = 1'b1; end
      OPC_XOR:    begin strobes.unit = UNIT_LOGIC; strobes.logicFn = LG_XOR; end
      OPC_XNOR:   begin strobes.unit = UNIT_LOGIC; strobes.logicFn = LG_XOR; strobes.invertB = 1'b1; end
      OPC_ORCB:   begin strobes.unit = UNIT_ORCB; end
      OPC_SEXTB:  begin strobes.unit = UNIT_SEXTB; end
      OPC_SEXTH:  begin strobes.unit = UNIT_SEXTH; end
      OPC_REV8:   begin strobes.unit = UNIT_REV8; end

      OPC_BEQ, OPC_BNE, OPC_BLT, OPC_BGE, OPC_BLTU, OPC_BGEU: begin
        strobes.isBranch = 1'b1;
        strobes.brInvert = opCode[1];
        case (opCode[3:2])
          2'b10:   strobes.brCmp = BR_LTS;
          2'b11:   strobes.brCmp = BR_LTU;
          default: strobes.brCmp = BR_EQ;
        endcase
      end

      default: strobes = '0;
    endcase
  end

endmodule

// File: rtl/rv_bitalu_datapath.sv
module rv_bitalu_datapath
  import rv_bitalu_pkg::*;
#(
  parameter int unsigned DATA_W = 64
) (
  input  alu_strobes_t      strobes,
  input  logic [DATA_W-1:0] srcA,
  input  logic [DATA_W-1:0] srcB,
  output logic [DATA_W-1:0] result,
  output logic              brTaken
);

  localparam int unsigned HALF_W = DATA_W / 2;
  localparam int unsigned SH_W   = $clog2(DATA_W);
  localparam int unsigned BYTES  = DATA_W / 8;
  localparam logic [SH_W:0] FULL_SPAN = (SH_W + 1)'(DATA_W);
  localparam logic [SH_W:0] HALF_SPAN = (SH_W + 1)'(HALF_W);

  // operand conditioning
  logic [DATA_W-1:0] opA;
  logic [SH_W-1:0]   shamt;
  logic [HALF_W-1:0] aLo;

  assign opA   = strobes.zextA ? {{HALF_W{1'b0}}, srcA[HALF_W-1:0]} : srcA;
  assign shamt = strobes.wordOp ? {1'b0, srcB[SH_W-2:0]} : srcB[SH_W-1:0];
  assign aLo   = srcA[HALF_W-1:0];

  // full-width shifter
  logic [SH_W:0]     fullComp;
  logic [DATA_W-1:0] fullSra;
  logic [DATA_W-1:0] fullShift;

  assign fullComp = FULL_SPAN - {1'b0, shamt};
  assign fullSra  = $signed(srcA) >>> shamt;

  always_comb begin
    case (strobes.shiftKind)
      SH_RLOG: fullShift = srcA >> shamt;
      SH_RARI: fullShift = fullSra;
      SH_ROL:  fullShift = (srcA << shamt) | (srcA >> fullComp);
      SH_ROR:  fullShift = (srcA >> shamt) | (srcA << fullComp);
      default: fullShift = opA << shamt;
    endcase
  end

  // word shifter
  logic [SH_W:0]     wordComp;
  logic [HALF_W-1:0] wordSra;
  logic [HALF_W-1:0] wordShift;

  assign wordComp = HALF_SPAN - {1'b0, shamt};
  assign wordSra  = $signed(aLo) >>> shamt;

  always_comb begin
    case (strobes.shiftKind)
      SH_RLOG: wordShift = aLo >> shamt;
      SH_RARI: wordShift = wordSra;
      SH_ROL:  wordShift = (aLo << shamt) | (aLo >> wordComp);
      SH_ROR:  wordShift = (aLo >> shamt) | (aLo << wordComp);
      default: wordShift = aLo << shamt;
    endcase
  end

  logic [DATA_W-1:0] shiftRes;
  assign shiftRes = strobes.wordOp ? {{HALF_W{wordShift[HALF_W-1]}}, wordShift} : fullShift;

  // adder shared by add, shift-add, subtract and word forms
  logic [DATA_W-1:0] addend;
  logic [DATA_W-1:0] sum;
  logic [DATA_W-1:0] arithRes;

  assign addend   = opA << strobes.preShift;
  assign sum      = strobes.subtract ? (addend - srcB) : (addend + srcB);
  assign arithRes = strobes.wordOp ? {{HALF_W{sum[HALF_W-1]}}, sum[HALF_W-1:0]} : sum;

  // comparator, kept apart from the adder
  logic lessS, lessU, equal, aLess;
  assign lessS = $signed(srcA) < $signed(srcB);
  assign lessU = srcA < srcB;
  assign equal = srcA == srcB;
  assign aLess = strobes.cmpSigned ? lessS : lessU;

  logic [DATA_W-1:0] lessRes, minMaxRes;
  assign lessRes   = {{(DATA_W-1){1'b0}}, aLess};
  assign minMaxRes = (strobes.pickMax ? !aLess : aLess) ? srcA : srcB;

  // logic unit
  logic [DATA_W-1:0] bOp, logicRes;
  assign bOp = strobes.invertB ? ~srcB : srcB;
  always_comb begin
    case (strobes.logicFn)
      LG_OR:   logicRes = srcA | bOp;
      LG_XOR:  logicRes = srcA ^ bOp;
      default: logicRes = srcA & bOp;
    endcase
  end

  // byte-wise functions
  logic [DATA_W-1:0] orcbRes, rev8Res;
  for (genvar gByte = 0; gByte < BYTES; gByte++) begin : g_byte
    assign orcbRes[8*gByte +: 8] = {8{|srcA[8*gByte +: 8]}};
    assign rev8Res[8*gByte +: 8] = srcA[8*(BYTES-1-gByte) +: 8];
  end

  logic [DATA_W-1:0] sextbRes, sexthRes;
  assign sextbRes = {{(DATA_W-8){srcA[7]}}, srcA[7:0]};
  assign sexthRes = {{(DATA_W-16){srcA[15]}}, srcA[15:0]};

  // single-bit unit
  logic [SH_W-1:0]   bitIdx;
  logic [DATA_W-1:0] bitMask, bitRes;
  assign bitIdx  = srcB[SH_W-1:0];
  assign bitMask = {{(DATA_W-1){1'b0}}, 1'b1} << bitIdx;
  always_comb begin
    case (strobes.bitOp)
      BIT_SET: bitRes = srcA | bitMask;
      BIT_EXT: bitRes = {{(DATA_W-1){1'b0}}, srcA[bitIdx]};
      default: bitRes = srcA & ~bitMask;
    endcase
  end

  // branch condition
  logic brCond;
  always_comb begin
    case (strobes.brCmp)
      BR_LTS:  brCond = lessS;
      BR_LTU:  brCond = lessU;
      default: brCond = equal;
    endcase
  end
  assign brTaken = strobes.isBranch & (brCond ^ strobes.brInvert);

  // result select
  always_comb begin
    case (strobes.unit)
      UNIT_SHIFT:  result = shiftRes;
      UNIT_BIT:    result = bitRes;
      UNIT_ARITH:  result = arithRes;
      UNIT_LESS:   result = lessRes;
      UNIT_MINMAX: result = minMaxRes;
      UNIT_LOGIC:  result = logicRes;
      UNIT_ORCB:   result = orcbRes;
      UNIT_SEXTB:  result = sextbRes;
      UNIT_SEXTH:  result = sexthRes;
      UNIT_REV8:   result = rev8Res;
      default:     result = '0;
    endcase
  end

endmodule

// File: rtl/rv_bitalu.sv
module rv_bitalu
  import rv_bitalu_pkg::*;
#(
  parameter int unsigned DATA_W = 64
) (
  input  logic [OP_W-1:0]   opCode,
  input  logic [DATA_W-1:0] srcA,
  input  logic [DATA_W-1:0] srcB,
  output logic [DATA_W-1:0] result,
  output logic              brTaken
);

  alu_strobes_t strobes;

  rv_bitalu_ctrl i_ctrl (
    .opCode  (opCode),
    .strobes (strobes)
  );

  rv_bitalu_datapath #(.DATA_W(DATA_W)) i_datapath (
    .strobes (strobes),
    .srcA    (srcA),
    .srcB    (srcB),
    .result  (result),
    .brTaken (brTaken)
  );

endmodule

// File: rtl/rv_bitalu_chk.sv
module rv_bitalu_chk
  import rv_bitalu_pkg::*;
#(
  parameter int unsigned DATA_W = 64
) (
  input logic [OP_W-1:0]   opCode,
  input logic [DATA_W-1:0] srcA,
  input logic [DATA_W-1:0] srcB,
  input logic [DATA_W-1:0] result,
  input logic              brTaken
);

  localparam int unsigned HALF_W = DATA_W / 2;

  always_comb begin
    // R2: taken only inside the branch class
    a_r2_taken_only_branch: assert (opCode[6:4] == 3'b111 || !brTaken);
    // R2: branches produce no result value
    a_r2_branch_zero_result: assert (opCode[6:4] != 3'b111 || result == '0);
    // R1: an unassigned code yields nothing
    a_r1_unassigned_quiet: assert (opCode != 7'h7F || (result == '0 && !brTaken));
    // R6: word class results are sign-extended
    a_r6_word_sext: assert (opCode[6:4] != 3'b001
                            || result[DATA_W-1:HALF_W] == {HALF_W{result[HALF_W-1]}});
    // R8: set-less-than is boolean
    a_r8_less_boolean: assert (!(opCode == 7'h31 || opCode == 7'h32)
                               || result[DATA_W-1:1] == '0);
    // R9: min and max return one of the operands
    a_r9_minmax_operand: assert (opCode[6:2] != 5'b01101
                                 || result == srcA || result == srcB);
    // R5: bit extract is boolean
    a_r5_bext_boolean: assert (opCode != 7'h06 || result[DATA_W-1:1] == '0);
  end

endmodule

bind rv_bitalu rv_bitalu_chk #(.DATA_W(DATA_W)) i_chk (
  .opCode  (opCode),
  .srcA    (srcA),
  .srcB    (srcB),
  .result  (result),
  .brTaken (brTaken)
);

// File: tb/test_rv_bitalu.sv
module test_rv_bitalu;

  localparam int CLK_PERIOD = 10;
  localparam int N_OPS   = 51;
  localparam int N_PAIRS = 8;

  localparam logic [6:0] OP_TABLE [N_OPS] = '{
    7'h00, 7'h01, 7'h02, 7'h03, 7'h05, 7'h06, 7'h07, 7'h09, 7'h0B,
    7'h10, 7'h12, 7'h18, 7'h19, 7'h1A, 7'h1C, 7'h1D,
    7'h20, 7'h21, 7'h28, 7'h29, 7'h2A, 7'h2B, 7'h2C, 7'h2D,
    7'h30, 7'h31, 7'h32, 7'h34, 7'h35, 7'h36, 7'h37,
    7'h40, 7'h41, 7'h42, 7'h43, 7'h44, 7'h45, 7'h46, 7'h48, 7'h4A, 7'h51,
    7'h70, 7'h72, 7'h78, 7'h7A, 7'h7C, 7'h7E,
    7'h04, 7'h11, 7'h74, 7'h7F
  };

  localparam logic [127:0] PAIR_TABLE [N_PAIRS] = '{
    {64'h0000_0000_0000_0000, 64'h0000_0000_0000_0000},
    {64'h8000_0000_F0F0_1234, 64'h0000_0000_0000_0045},
    {64'hFFFF_FFFF_FFFF_FFFF, 64'h0000_0000_0000_0001},
    {64'h0123_4567_89AB_CDEF, 64'hFEDC_BA98_7654_3210},
    {64'h7FFF_FFFF_8000_0000, 64'h7FFF_FFFF_8000_0000},
    {64'h0000_0000_8000_00FF, 64'hFFFF_FFFF_FFFF_FFBF},
    {64'h0000_0000_0000_0001, 64'h8000_0000_0000_0000},
    {64'hDEAD_BEEF_0000_0080, 64'h0000_0000_0000_0020}
  };

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [6:0]  opCode;
  logic [63:0] srcA, srcB, result;
  logic        brTaken;
  int testsRun = 0;
  int testsFailed = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  rv_bitalu i_rv_bitalu (
    .opCode(opCode), .srcA(srcA), .srcB(srcB), .result(result), .brTaken(brTaken)
  );

  // reference helpers, bit by bit
  function automatic logic [63:0] refShl(logic [63:0] x, int n, int w);
    logic [63:0] r = '0;
    for (int i = 0; i < w; i++) if (i >= n) r[i] = x[i-n];
    return r;
  endfunction

  function automatic logic [63:0] refShr(logic [63:0] x, int n, int w, logic fill);
    logic [63:0] r = '0;
    for (int i = 0; i < w; i++) r[i] = (i + n < w) ? x[i+n] : fill;
    return r;
  endfunction

  function automatic logic [63:0] refRor(logic [63:0] x, int n, int w);
    logic [63:0] r = '0;
    for (int i = 0; i < w; i++) r[i] = x[(i + n) % w];
    return r;
  endfunction

  function automatic logic [63:0] sx32(logic [63:0] x);
    return {{32{x[31]}}, x[31:0]};
  endfunction

  function automatic logic [64:0] refModel(logic [6:0] op, logic [63:0] a, logic [63:0] b);
    logic [63:0] r = '0;
    logic t = 1'b0;
    logic [63:0] az = {32'h0, a[31:0]};
    int s6 = int'(b[5:0]);
    int s5 = int'(b[4:0]);
    case (op)
      7'h00: r = refShl(az, s6, 64);
      7'h01: r = refShl(a, s6, 64);
      7'h02: begin r = a; r[s6] = 1'b0; end
      7'h03: begin r = a; r[s6] = 1'b1; end
      7'h05: r = refShr(a, s6, 64, 1'b0);
      7'h06: r = {63'h0, a[s6]};
      7'h07: r = refShr(a, s6, 64, a[63]);
      7'h09: r = refRor(a, (64 - s6) % 64, 64);
      7'h0B: r = refRor(a, s6, 64);
      7'h10: r = sx32(a + b);
      7'h12: r = sx32(a - b);
      7'h18: r = sx32(refShl(az, s5, 32));
      7'h19: r = sx32(refShr(az, s5, 32, 1'b0));
      7'h1A: r = sx32(refShr(az, s5, 32, a[31]));
      7'h1C: r = sx32(refRor(az, (32 - s5) % 32, 32));
      7'h1D: r = sx32(refRor(az, s5, 32));
      7'h20: r = az + b;
      7'h21: r = a + b;
      7'h28: r = az * 2 + b;
      7'h29: r = a * 2 + b;
      7'h2A: r = az * 4 + b;
      7'h2B: r = a * 4 + b;
      7'h2C: r = az * 8 + b;
      7'h2D: r = a * 8 + b;
      7'h30: r = a - b;
      7'h31: r = (a < b) ? 64'd1 : 64'd0;
      7'h32: r = ($signed(a) < $signed(b)) ? 64'd1 : 64'd0;
      7'h34: r = (a > b) ? a : b;
      7'h35: r = (a < b) ? a : b;
      7'h36: r = ($signed(a) > $signed(b)) ? a : b;
      7'h37: r = ($signed(a) < $signed(b)) ? a : b;
      7'h40: r = a & b;
      7'h41: r = a & ~b;
      7'h42: r = a | b;
      7'h43: r = a | ~b;
      7'h44: r = a ^ b;
      7'h45: r = ~(a ^ b);
      7'h46: for (int k = 0; k < 8; k++) r[8*k +: 8] = (a[8*k +: 8] != 0) ? 8'hFF : 8'h00;
      7'h48: r = {{56{a[7]}}, a[7:0]};
      7'h4A: r = {{48{a[15]}}, a[15:0]};
      7'h51: for (int k = 0; k < 8; k++) r[8*k +: 8] = a[8*(7-k) +: 8];
      7'h70: t = (a == b);
      7'h72: t = (a != b);
      7'h78: t = ($signed(a) < $signed(b));
      7'h7A: t = ($signed(a) >= $signed(b));
      7'h7C: t = (a < b);
      7'h7E: t = (a >= b);
      default: begin r = '0; t = 1'b0; end
    endcase
    return {t, r};
  endfunction

  function automatic string reqOf(logic [6:0] op);
    case (op)
      7'h00: return "R4";
      7'h01, 7'h05, 7'h07, 7'h09, 7'h0B: return "R3";
      7'h02, 7'h03, 7'h06: return "R5";
      7'h10, 7'h12, 7'h18, 7'h19, 7'h1A, 7'h1C, 7'h1D: return "R6";
      7'h20, 7'h21, 7'h28, 7'h29, 7'h2A, 7'h2B, 7'h2C, 7'h2D: return "R7";
      7'h30, 7'h31, 7'h32: return "R8";
      7'h34, 7'h35, 7'h36, 7'h37: return "R9";
      7'h40, 7'h41, 7'h42, 7'h43, 7'h44, 7'h45: return "R10";
      7'h46, 7'h48, 7'h4A, 7'h51: return "R11";
      7'h70, 7'h72, 7'h78, 7'h7A, 7'h7C, 7'h7E: return "R2";
      default: return "R1";
    endcase
  endfunction

  task automatic checkOp(input logic [6:0] op, input logic [63:0] a, input logic [63:0] b,
                         input logic [63:0] expRes, input logic expTaken, input string req);
    @(negedge clk);
    opCode = op; srcA = a; srcB = b;
    #1;
    testsRun++;
    if (result !== expRes || brTaken !== expTaken) begin
      testsFailed++;
      $display("FAIL %s op=%h a=%h b=%h: result=%h taken=%b expected result=%h taken=%b",
               req, op, a, b, result, brTaken, expRes, expTaken);
    end
  endtask

  task automatic checkModel(input logic [6:0] op, input logic [63:0] a, input logic [63:0] b);
    logic [64:0] e = refModel(op, a, b);
    checkOp(op, a, b, e[63:0], e[64], reqOf(op));
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    testsFailed++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end

  initial begin
    opCode = '0; srcA = '0; srcB = '0;
    repeat (3) @(posedge clk);
    rstN = 1'b1;
    // reset state: all-zero inputs give zero outputs (R4 with zero operand)
    checkOp(7'h00, 64'h0, 64'h0, 64'h0, 1'b0, "R4 reset");

    // table walk: every opcode across every operand pair
    for (int p = 0; p < N_PAIRS; p++)
      for (int o = 0; o < N_OPS; o++)
        checkModel(OP_TABLE[o], PAIR_TABLE[p][127:64], PAIR_TABLE[p][63:0]);

    // full opcode sweep, unlisted codes must be quiet (R1)
    for (int o = 0; o < 128; o++)
      checkModel(7'(o), 64'h0123_4567_89AB_CDEF, 64'hFEDC_BA98_7654_3210);

    // directed corner cases
    checkOp(7'h06, 64'h8000_0000_0000_0000, 64'd63, 64'h1, 1'b0, "R5 bext top bit");
    checkOp(7'h02, 64'hFFFF_FFFF_FFFF_FFFF, 64'hC0, 64'hFFFF_FFFF_FFFF_FFFE, 1'b0, "R5 bclr index masked");
    checkOp(7'h07, 64'h8000_0000_0000_0000, 64'h43, 64'hF000_0000_0000_0000, 1'b0, "R3 sra amount masked");
    checkOp(7'h09, 64'h8000_0000_0000_0001, 64'h0, 64'h8000_0000_0000_0001, 1'b0, "R3 rol by zero");
    checkOp(7'h1D, 64'h1, 64'h21, 64'hFFFF_FFFF_8000_0000, 1'b0, "R6 rorw amount masked");
    checkOp(7'h10, 64'h0000_0000_7FFF_FFFF, 64'h1, 64'hFFFF_FFFF_8000_0000, 1'b0, "R6 addw overflow");
    checkOp(7'h00, 64'hFFFF_FFFF_8000_0001, 64'h1, 64'h0000_0001_0000_0002, 1'b0, "R4 slliuw");
    checkOp(7'h2C, 64'hFFFF_FFFF_0000_0001, 64'h2, 64'hA, 1'b0, "R7 sh3adduw");
    checkOp(7'h31, 64'h0, 64'h1, 64'h1, 1'b0, "R8 sltu");
    checkOp(7'h32, 64'hFFFF_FFFF_FFFF_FFFF, 64'h0, 64'h1, 1'b0, "R8 slt negative");
    checkOp(7'h36, 64'hFFFF_FFFF_FFFF_FFFF, 64'h1, 64'h1, 1'b0, "R9 max signed");
    checkOp(7'h34, 64'hFFFF_FFFF_FFFF_FFFF, 64'h1, 64'hFFFF_FFFF_FFFF_FFFF, 1'b0, "R9 maxu");
    checkOp(7'h45, 64'h0, 64'h0, 64'hFFFF_FFFF_FFFF_FFFF, 1'b0, "R10 xnor");
    checkOp(7'h51, 64'h0102_0304_0506_0708, 64'h0, 64'h0807_0605_0403_0201, 1'b0, "R11 rev8");
    checkOp(7'h46, 64'h0001_0000_8000_0000, 64'h0, 64'h00FF_0000_FF00_0000, 1'b0, "R11 orc.b");
    checkOp(7'h78, 64'hFFFF_FFFF_FFFF_FFFF, 64'h0, 64'h0, 1'b1, "R2 blt taken");
    checkOp(7'h7C, 64'hFFFF_FFFF_FFFF_FFFF, 64'h0, 64'h0, 1'b0, "R2 bltu not taken");
    checkOp(7'h7E, 64'hFFFF_FFFF_FFFF_FFFF, 64'h0, 64'h0, 1'b1, "R2 bgeu taken");
    checkOp(7'h72, 64'h5, 64'h5, 64'h0, 1'b0, "R2 bne equal");
    checkOp(7'h74, 64'h5, 64'h5, 64'h0, 1'b0, "R1 reserved branch type");
    checkOp(7'h7F, 64'h5, 64'h6, 64'h0, 1'b0, "R1 top code");

    $display("  [TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end

endmodule